// File: doc/BRIEF.md
# Bit-Stuffing NRZI Line Encoder with Loopback Decoder

This block turns a serial bit stream into the differential line signalling of a full-speed serial bus transmitter. An upstream source offers one bit per cycle with a valid/ready handshake and marks the final bit of each packet. Whenever six ones in a row have been sent, the encoder slips in a zero so the line keeps changing level. While it sends that zero it holds off the source. Every bit, data or inserted, is NRZI coded. The result is driven as two complementary line levels together with an output-enable. After the last bit the block signals end of packet, then releases the line.

A companion receive path takes two line levels and a line-active qualifier. It undoes the NRZI coding, drops the inserted zeros and reports each recovered data bit. It also reports the end-of-packet marker and a bad inserted bit. Connecting the transmit outputs to the receive inputs gives a loopback path for checking a whole link. In this design one bit time is one clock cycle.

Top module: `serial_line_codec`

## Requirements
- R1: After reset, line_p is 1, line_n is 0, line_oe is 0 and in_ready is 1. rx_valid, rx_eop and rx_stuff_err are all 0.
- R2: Each bit sent appears on the line in the cycle after it is sent. A 0 inverts line_p relative to the previous bit time and a 1 leaves it unchanged. The first bit of a packet is coded against the idle level, line_p = 1.
- R3: While line_oe is 1 and the line is not in the both-low state, line_n is the inverse of line_p.
- R4: After RUN_LEN (6) consecutive ones, a 0 bit is inserted on the line. The run count restarts after every inserted bit, after every data 0 and at the start of each packet, so the line never holds one level for more than seven driven bit times.
- R5: in_ready is 0 in every cycle in which an inserted bit is being sent. Every offered data bit still reaches the line exactly once and in order.
- R6: If a packet ends with a run that reaches six ones, the inserted 0 is sent before the end-of-packet signalling.
- R7: End of packet is sent after the last bit and any inserted bit that follows it. It is SE0_BITS (2) cycles with both lines 0, then one cycle with line_p = 1 and line_n = 0, all with line_oe = 1. In the next cycle line_oe is 0. in_ready is 0 from the cycle after the last bit is accepted until line_oe returns to 0.
- R8: While no packet is in progress, the line stays at line_p = 1, line_n = 0, line_oe = 0. Changes on in_bit while in_valid is 0 have no effect on the line.
- R9: While rx_en is 1, each received bit time is decoded: a level equal to the previous bit time is a 1 and a change is a 0, starting from the idle level 1. rx_valid and rx_bit report that decoded bit one cycle later. The bit that follows six consecutive decoded ones is discarded and does not raise rx_valid.
- R10: If a discarded bit decodes as 1, rx_stuff_err pulses for one cycle, and the run count restarts.
- R11: The first cycle with both rx_p and rx_n at 0 while rx_en is 1 produces a single rx_eop pulse one cycle later. All further bit times are ignored until rx_en returns to 0, which restores the idle level and clears the run count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one bit time per cycle |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Source offers a bit |
| in_bit | input | 1 | Offered data bit |
| in_last | input | 1 | Offered bit is the final bit of the packet |
| in_ready | output | 1 | Encoder takes the offered bit this cycle |
| line_p | output | 1 | Positive line level |
| line_n | output | 1 | Negative line level |
| line_oe | output | 1 | Line drive enable |
| rx_en | input | 1 | Receive line is being driven |
| rx_p | input | 1 | Received positive line level |
| rx_n | input | 1 | Received negative line level |
| rx_valid | output | 1 | Pulse: a decoded data bit is on rx_bit |
| rx_bit | output | 1 | Decoded data bit |
| rx_eop | output | 1 | Pulse: end-of-packet state seen |
| rx_stuff_err | output | 1 | Pulse: the bit after six ones was a one |

## Verification
Every 10-bit packet pattern is pushed through the loopback. For each one the bench compares the full line trace with one it builds arithmetically, so an encoder that counts a run as five or seven ones, or forgets to restart the count after a zero, shows a shifted trace. Packets that end on exactly six and twelve ones catch an encoder that starts end of packet before the trailing inserted bit. Counting the cycles in which the source is held off exposes a stall that drops or repeats a data bit. A hand-built receive stream with a bad inserted one, and with line activity after the end marker, shows a decoder that misses the error, passes the discarded bit through, or keeps decoding after end of packet.

// File: rtl/linecode_pkg.sv
package linecode_pkg;
  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_DATA = 2'd1,
    TX_SE0  = 2'd2,
    TX_JEND = 2'd3
  } tx_state_e;

  localparam logic IDLE_P = 1'b1;
  localparam logic IDLE_N = 1'b0;
endpackage

// File: rtl/tx_stuffer.sv
module tx_stuffer #(
  parameter int RUN_LEN = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic in_bit,
  input  logic in_last,
  input  logic drv_ready,
  output logic in_ready,
  output logic sym_valid,
  output logic sym_bit,
  output logic sym_eop
);
  localparam int CW = $clog2(RUN_LEN + 1);

  logic [CW-1:0] ones_q;
  logic          eop_pend_q;
  logic          stuff_now;

  always_comb begin
    stuff_now = (ones_q == CW'(RUN_LEN));
    in_ready  = drv_ready && !stuff_now && !eop_pend_q;
    sym_valid = drv_ready && (stuff_now || eop_pend_q || in_valid);
    sym_eop   = !stuff_now && eop_pend_q;
    sym_bit   = stuff_now ? 1'b0 : in_bit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ones_q     <= '0;
      eop_pend_q <= 1'b0;
    end else begin
      if (sym_valid) begin
        if (sym_eop || !sym_bit) ones_q <= '0;
        else                     ones_q <= ones_q + 1'b1;
      end
      if (in_valid && in_ready && in_last) eop_pend_q <= 1'b1;
      else if (sym_valid && sym_eop)       eop_pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/tx_line_driver.sv
module tx_line_driver #(
  parameter int SE0_BITS = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sym_valid,
  input  logic sym_bit,
  input  logic sym_eop,
  output logic drv_ready,
  output logic line_p,
  output logic line_n,
  output logic line_oe
);
  import linecode_pkg::*;

  localparam int EW = $clog2(SE0_BITS + 1);

  tx_state_e     st_q;
  logic [EW-1:0] se0_q;

  assign drv_ready = (st_q == TX_IDLE) || (st_q == TX_DATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= TX_IDLE;
      se0_q   <= '0;
      line_p  <= IDLE_P;
      line_n  <= IDLE_N;
      line_oe <= 1'b0;
    end else begin
      case (st_q)
        TX_IDLE, TX_DATA: begin
          if (sym_valid) begin
            line_oe <= 1'b1;
            if (sym_eop) begin
              line_p <= 1'b0;
              line_n <= 1'b0;
              se0_q  <= EW'(1);
              st_q   <= TX_SE0;
            end else begin
              line_p <= sym_bit ? line_p : ~line_p;
              line_n <= sym_bit ? ~line_p : line_p;
              st_q   <= TX_DATA;
            end
          end
        end
        TX_SE0: begin
          if (se0_q < EW'(SE0_BITS)) begin
            line_p <= 1'b0;
            line_n <= 1'b0;
            se0_q  <= se0_q + 1'b1;
          end else begin
            line_p <= IDLE_P;
            line_n <= IDLE_N;
            st_q   <= TX_JEND;
          end
        end
        default: begin
          line_oe <= 1'b0;
          line_p  <= IDLE_P;
          line_n  <= IDLE_N;
          st_q    <= TX_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/rx_destuffer.sv
module rx_destuffer #(
  parameter int RUN_LEN = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_en,
  input  logic rx_p,
  input  logic rx_n,
  output logic rx_valid,
  output logic rx_bit,
  output logic rx_eop,
  output logic rx_stuff_err
);
  import linecode_pkg::*;

  localparam int CW = $clog2(RUN_LEN + 1);

  logic [CW-1:0] ones_q;
  logic          prev_q;
  logic          eop_seen_q;
  logic          se0;
  logic          dbit;

  always_comb begin
    se0  = !rx_p && !rx_n;
    dbit = (rx_p == prev_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ones_q       <= '0;
      prev_q       <= IDLE_P;
      eop_seen_q   <= 1'b0;
      rx_valid     <= 1'b0;
      rx_bit       <= 1'b0;
      rx_eop       <= 1'b0;
      rx_stuff_err <= 1'b0;
    end else begin
      rx_valid     <= 1'b0;
      rx_eop       <= 1'b0;
      rx_stuff_err <= 1'b0;
      if (!rx_en) begin
        prev_q     <= IDLE_P;
        ones_q     <= '0;
        eop_seen_q <= 1'b0;
      end else if (!eop_seen_q) begin
        if (se0) begin
          rx_eop     <= 1'b1;
          eop_seen_q <= 1'b1;
          ones_q     <= '0;
        end else begin
          prev_q <= rx_p;
          if (ones_q == CW'(RUN_LEN)) begin
            ones_q       <= '0;
            rx_stuff_err <= dbit;
          end else begin
            rx_valid <= 1'b1;
            rx_bit   <= dbit;
            ones_q   <= dbit ? ones_q + 1'b1 : '0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/serial_line_codec.sv
module serial_line_codec #(
  parameter int RUN_LEN  = 6,
  parameter int SE0_BITS = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic in_bit,
  input  logic in_last,
  output logic in_ready,
  output logic line_p,
  output logic line_n,
  output logic line_oe,
  input  logic rx_en,
  input  logic rx_p,
  input  logic rx_n,
  output logic rx_valid,
  output logic rx_bit,
  output logic rx_eop,
  output logic rx_stuff_err
);
  logic drv_ready;
  logic sym_valid;
  logic sym_bit;
  logic sym_eop;

  tx_stuffer #(.RUN_LEN(RUN_LEN)) u_stuff (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_bit(in_bit), .in_last(in_last),
    .drv_ready(drv_ready), .in_ready(in_ready),
    .sym_valid(sym_valid), .sym_bit(sym_bit), .sym_eop(sym_eop)
  );

  tx_line_driver #(.SE0_BITS(SE0_BITS)) u_drv (
    .clk(clk), .rst(rst),
    .sym_valid(sym_valid), .sym_bit(sym_bit), .sym_eop(sym_eop),
    .drv_ready(drv_ready),
    .line_p(line_p), .line_n(line_n), .line_oe(line_oe)
  );

  rx_destuffer #(.RUN_LEN(RUN_LEN)) u_rx (
    .clk(clk), .rst(rst),
    .rx_en(rx_en), .rx_p(rx_p), .rx_n(rx_n),
    .rx_valid(rx_valid), .rx_bit(rx_bit),
    .rx_eop(rx_eop), .rx_stuff_err(rx_stuff_err)
  );
endmodule

// File: rtl/serial_line_codec_chk.sv
module serial_line_codec_chk #(
  parameter int RUN_LEN = 6
) (
  input logic clk,
  input logic rst,
  input logic in_ready,
  input logic line_p,
  input logic line_n,
  input logic line_oe,
  input logic rx_en,
  input logic rx_p,
  input logic rx_n,
  input logic rx_valid,
  input logic rx_eop,
  input logic rx_stuff_err
);
  localparam int HW = $clog2(RUN_LEN + 4);
  localparam logic [HW-1:0] HMAX = {HW{1'b1}};

  logic [HW-1:0] hold_q;
  logic          prev_drv_q;
  logic          prev_p_q;
  logic          drv_data;

  assign drv_data = line_oe && (line_p || line_n);

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q     <= '0;
      prev_drv_q <= 1'b0;
      prev_p_q   <= 1'b1;
    end else begin
      prev_drv_q <= drv_data;
      prev_p_q   <= line_p;
      if (!drv_data)                           hold_q <= '0;
      else if (prev_drv_q && line_p == prev_p_q) hold_q <= (hold_q == HMAX) ? hold_q : hold_q + 1'b1;
      else                                     hold_q <= HW'(1);
    end
  end

  AST_DIFF_PAIR: assert property (@(posedge clk) disable iff (rst)
    drv_data |-> (line_p != line_n)); // R3
  AST_IDLE_J: assert property (@(posedge clk) disable iff (rst)
    !line_oe |-> (line_p && !line_n)); // R8
  AST_RUN_BOUND: assert property (@(posedge clk) disable iff (rst)
    hold_q <= HW'(RUN_LEN + 1)); // R4
  AST_NO_READY_IN_EOP: assert property (@(posedge clk) disable iff (rst)
    (line_oe && !line_p && !line_n) |-> !in_ready); // R7
  AST_RELEASE_AFTER_J: assert property (@(posedge clk) disable iff (rst)
    $fell(line_oe) |-> $past(line_p && !line_n)); // R7
  AST_VALID_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> $past(rx_en)); // R9
  AST_ERR_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    rx_stuff_err |-> $past(rx_en)); // R10
  AST_EOP_FROM_SE0: assert property (@(posedge clk) disable iff (rst)
    rx_eop |-> $past(rx_en && !rx_p && !rx_n)); // R11
endmodule

bind serial_line_codec serial_line_codec_chk #(.RUN_LEN(RUN_LEN)) u_chk (
  .clk(clk), .rst(rst), .in_ready(in_ready),
  .line_p(line_p), .line_n(line_n), .line_oe(line_oe),
  .rx_en(rx_en), .rx_p(rx_p), .rx_n(rx_n),
  .rx_valid(rx_valid), .rx_eop(rx_eop), .rx_stuff_err(rx_stuff_err)
);

// File: tb/serial_line_codec_bench.sv
module serial_line_codec_bench;
  localparam int RL = 6;
  localparam int SE = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic in_valid = 1'b0, in_bit = 1'b0, in_last = 1'b0;
  logic inj = 1'b0, inj_en = 1'b0, inj_p = 1'b1, inj_n = 1'b0;
  logic in_ready, line_p, line_n, line_oe;
  logic rx_valid, rx_bit, rx_eop, rx_stuff_err;
  logic rx_en, rx_p, rx_n;

  assign rx_en = inj ? inj_en : line_oe;
  assign rx_p  = inj ? inj_p  : line_p;
  assign rx_n  = inj ? inj_n  : line_n;

  serial_line_codec #(.RUN_LEN(RL), .SE0_BITS(SE)) u_serial_line_codec (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_bit(in_bit), .in_last(in_last), .in_ready(in_ready),
    .line_p(line_p), .line_n(line_n), .line_oe(line_oe),
    .rx_en(rx_en), .rx_p(rx_p), .rx_n(rx_n),
    .rx_valid(rx_valid), .rx_bit(rx_bit), .rx_eop(rx_eop), .rx_stuff_err(rx_stuff_err)
  );

  int checks = 0;
  int fails  = 0;
  logic pkt [0:255];
  logic exp_p [0:511];
  logic exp_n [0:511];
  logic exp_oe [0:511];
  int exp_len, exp_stalls;
  logic rx_buf [0:511];
  int rx_cnt = 0, eop_cnt = 0, err_cnt = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (rx_valid) begin
        if (rx_cnt < 512) rx_buf[rx_cnt] = rx_bit;
        rx_cnt++;
      end
      if (rx_eop) eop_cnt++;
      if (rx_stuff_err) err_cnt++;
    end
  end

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic push(input int p, input int n, input int oe);
    exp_p[exp_len] = p[0]; exp_n[exp_len] = n[0]; exp_oe[exp_len] = oe[0];
    exp_len++;
  endtask

  task automatic build_expected(input int len);
    int ones = 0;
    int lvl = 1;
    exp_len = 0;
    exp_stalls = 0;
    for (int b = 0; b < len; b++) begin
      if (!pkt[b]) lvl = 1 - lvl;
      push(lvl, 1 - lvl, 1);
      ones = pkt[b] ? ones + 1 : 0;
      if (ones == RL) begin
        lvl = 1 - lvl;
        push(lvl, 1 - lvl, 1);
        ones = 0;
        if (b < len - 1) exp_stalls++;
      end
    end
    for (int s = 0; s < SE; s++) push(0, 0, 1);
    push(1, 0, 1);
    push(1, 0, 0);
  endtask

  task automatic run_pkt(input int len, input string tag);
    int i = 0, n = 0, stalls = 0, cyc = 0, mism = -1, mact = 0, mexp = 0;
    bit on = 0, done = 0, acc;
    int bad_bit = -1;
    rx_cnt = 0; eop_cnt = 0; err_cnt = 0;
    build_expected(len);
    while (!done && cyc < 2000) begin
      @(negedge clk);
      cyc++;
      if (line_oe) on = 1;
      if (on) begin
        if (mism < 0) begin
          if (n >= exp_len) begin
            mism = n; mact = 1; mexp = 0;
          end else if (line_p !== exp_p[n] || line_n !== exp_n[n] || line_oe !== exp_oe[n]) begin
            mism = n;
            mact = {29'd0, line_oe, line_p, line_n};
            mexp = {29'd0, exp_oe[n], exp_p[n], exp_n[n]};
          end
        end
        n++;
        if (!line_oe) done = 1;
      end
      in_valid = (i < len);
      in_bit   = (i < len) ? pkt[i] : 1'b0;
      in_last  = (i == len - 1);
      if (i < len && i > 0 && !in_ready) stalls++;
      acc = in_valid && in_ready;
      if (!done) begin
        @(posedge clk);
        if (acc) i++;
      end
    end
    in_valid = 1'b0; in_last = 1'b0;
    check(mism < 0 && n == exp_len,
          $sformatf("R2 R3 R4 R6 R7 line trace %s (oe,p,n at step %0d)", tag, mism), mact, mexp);
    check(stalls == exp_stalls, $sformatf("R5 stall cycles %s", tag), stalls, exp_stalls);
    check(in_ready === 1'b1, $sformatf("R7 ready back after release %s", tag), in_ready, 1);
    for (int k = 0; k < len && k < rx_cnt; k++)
      if (bad_bit < 0 && rx_buf[k] !== pkt[k]) bad_bit = k;
    check(rx_cnt == len && bad_bit < 0, $sformatf("R9 loopback bits %s (first bad %0d)", tag, bad_bit), rx_cnt, len);
    check(eop_cnt == 1, $sformatf("R11 loopback eop %s", tag), eop_cnt, 1);
    check(err_cnt == 0, $sformatf("R10 no stuff error %s", tag), err_cnt, 0);
  endtask

  task automatic inj_bits;
    logic bits [0:8];
    int lvl = 1;
    bits[0] = 0;
    for (int k = 1; k <= 7; k++) bits[k] = 1;
    bits[8] = 0;
    rx_cnt = 0; eop_cnt = 0; err_cnt = 0;
    @(negedge clk);
    inj = 1'b1; inj_en = 1'b0; inj_p = 1'b1; inj_n = 1'b0;
    for (int k = 0; k <= 8; k++) begin
      @(negedge clk);
      if (!bits[k]) lvl = 1 - lvl;
      inj_en = 1'b1; inj_p = lvl[0]; inj_n = ~lvl[0];
    end
    for (int s = 0; s < SE; s++) begin
      @(negedge clk); inj_p = 1'b0; inj_n = 1'b0;
    end
    @(negedge clk); inj_p = 1'b1; inj_n = 1'b0;
    @(negedge clk); inj_p = 1'b0; inj_n = 1'b1;
    @(negedge clk); inj_p = 1'b1; inj_n = 1'b0;
    @(negedge clk); inj_en = 1'b0;
    repeat (3) @(negedge clk);
    inj = 1'b0;
    check(err_cnt == 1, "R10 bad inserted one flagged", err_cnt, 1);
    check(rx_cnt == 8, "R9 R10 bad inserted bit discarded", rx_cnt, 8);
    check(rx_cnt >= 8 && rx_buf[0] == 0 && rx_buf[1] == 1 && rx_buf[6] == 1 && rx_buf[7] == 0,
          "R9 decoded bits around error", rx_cnt, 8);
    check(eop_cnt == 1, "R11 single eop, later activity ignored", eop_cnt, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired R1 actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    check(line_p === 1 && line_n === 0 && line_oe === 0, "R1 reset line state",
          {line_oe, line_p, line_n}, 3'b010);
    check(in_ready === 1 && rx_valid === 0 && rx_eop === 0 && rx_stuff_err === 0,
          "R1 reset ready and receive flags", {in_ready, rx_valid, rx_eop, rx_stuff_err}, 4'b1000);

    begin
      int bad = 0;
      for (int k = 0; k < 10; k++) begin
        in_bit = k[0]; in_last = k[1];
        @(negedge clk);
        if (!(line_p === 1 && line_n === 0 && line_oe === 0)) bad++;
      end
      check(bad == 0, "R8 idle line ignores in_bit without valid", bad, 0);
      in_bit = 0; in_last = 0;
    end

    pkt[0] = 1; run_pkt(1, "single one");
    pkt[0] = 0; run_pkt(1, "single zero");
    for (int k = 0; k < 6; k++) pkt[k] = 1;
    run_pkt(6, "six ones R6");
    for (int k = 0; k < 12; k++) pkt[k] = 1;
    run_pkt(12, "twelve ones R6");
    for (int k = 0; k < 20; k++) pkt[k] = 1;
    run_pkt(20, "twenty ones R4");
    for (int k = 0; k < 5; k++) pkt[k] = 1;
    pkt[5] = 0; pkt[6] = 1;
    run_pkt(7, "five ones then zero R4");

    for (int v = 0; v < 1024; v++) begin
      for (int b = 0; b < 10; b++) pkt[b] = v[b];
      run_pkt(10, $sformatf("pattern %0d", v));
      repeat (v % 3) @(negedge clk);
    end

    lfsr = 16'hACE1;
    for (int k = 0; k < 150; k++) begin
      pkt[k] = lfsr[0] | lfsr[3];
      lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
    end
    run_pkt(150, "long mixed");

    inj_bits();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule